// File: doc/BRIEF.md
# USB-C Alternate-Mode Crosspoint Controller

This block turns three slow, asynchronous board-level control pins into the digital selects that steer a USB-C crosspoint switch. Two mode pins choose between power-down, USB-only, four-lane DisplayPort, and USB plus two-lane DisplayPort. An orientation pin tells the block which way the plug is inserted. For each of the four DisplayPort output lanes the block drives a source index and a valid bit. It drives one pair select for the SuperSpeed receive/transmit path. It also drives a connect and a swap control for the sideband (AUX to SBU) switch, and a power-down flag.

Every pin first passes through a two-flop synchronizer. After reset the block is forced into USB-only routing and ignores both mode pins. It starts following them only after mode pin 0 has been seen high and then low again. The sideband switch connects as soon as the effective mode pin 1 is high. It opens only after that pin has been low without a break for longer than a programmable timeout, about 2 ms by default. The timeout length is derived from the clock frequency parameter.

Top module: `typec_altmode_ctrl`

## Requirements
- R1: While reset is held and just after it, the block reports USB-only routing: `pwr_dn_o`=0, `ss_vld_o`=1, `dp_vld_o`=0, `dp_src_o`=0, and `sbu_conn_o`=0.
- R2: Until released, the block keeps USB-only routing whatever the mode pins do, and the sideband stays open even with `mode1_i` high. `ss_pair_o` still follows `orient_i`.
- R3: Once `mode0_i` has been high and then low, the routing follows the mode pins, and it is never forced again until the next reset.
- R4: With both mode pins low, `pwr_dn_o`=1 and `dp_vld_o`, `dp_src_o`, `ss_vld_o` and `ss_pair_o` are all 0, whatever `orient_i` is.
- R5: With `mode1_i`=0 and `mode0_i`=1 (USB-only), `ss_vld_o`=1, `ss_pair_o` equals `orient_i` (0 = connector pair 1, 1 = pair 2), and no DisplayPort lane is valid.
- R6: With `mode1_i`=1 and `mode0_i`=0 (4-lane DP), all four lanes are valid and `ss_vld_o`=0. The source codes are 0=TX1, 1=RX1, 2=TX2, 3=RX2, and lane n sits at `dp_src_o[2n+1:2n]`. Unflipped, lanes 0..3 take TX2, RX2, RX1, TX1. Flipped, they take TX1, RX1, RX2, TX2.
- R7: With both mode pins high (USB + 2-lane DP), lanes 0 and 1 are valid and take TX2 and RX2 when unflipped, or TX1 and RX1 when flipped. USB uses the other pair (`ss_pair_o`=`orient_i`). Lanes 2 and 3 are invalid with source code 0.
- R8: A routing change appears at the outputs two clock edges after the pin change. A released, high `mode1_i` sets `sbu_conn_o`=1 one edge after that. `sbu_swap_o` equals `orient_i`, where 0 means SBU1 to AUXn and SBU2 to AUXp, and 1 means the reverse.
- R9: If `mode1_i` falls and stays low, `sbu_conn_o` is still 1 after TIMEOUT_CYC+2 clock edges and is 0 after TIMEOUT_CYC+3. TIMEOUT_CYC is CLK_KHZ*TIMEOUT_US/1000.
- R10: Any high on `mode1_i` restarts the timeout, so low periods do not add up, and it reconnects an open sideband switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode1_i | input | 1 | Asynchronous mode pin 1 (DisplayPort enable) |
| mode0_i | input | 1 | Asynchronous mode pin 0 (USB enable, release pulse) |
| orient_i | input | 1 | Asynchronous plug orientation (1 = flipped) |
| dp_src_o | output | 8 | Source code per DisplayPort lane, 2 bits each |
| dp_vld_o | output | 4 | Per-lane valid |
| ss_vld_o | output | 1 | SuperSpeed path routed |
| ss_pair_o | output | 1 | SuperSpeed connector pair (0 = pair 1, 1 = pair 2) |
| sbu_conn_o | output | 1 | Sideband switch closed |
| sbu_swap_o | output | 1 | Sideband cross mapping |
| pwr_dn_o | output | 1 | Power-down indication |

## Verification
The bench builds the block with CLK_KHZ=10 and TIMEOUT_US=2000, which makes the sideband timeout 20 cycles instead of half a million. With that setting the bench can test the open timing exactly one edge before and at the expiry edge. It can also test the counter restart in a short run. The mode and lane behaviour does not depend on the parameters, so all eight pin combinations are still swept against a permutation table written in the bench.

// File: rtl/typec_mux_pkg.sv
package typec_mux_pkg;

    localparam int DP_LANES = 4;
    localparam int SRC_W    = 2;
    localparam int DP2_LANES = DP_LANES / 2;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_USB     = 2'd1,
        MODE_DP4     = 2'd2,
        MODE_USB_DP2 = 2'd3
    } mode_e;

    // bit 1 selects the connector pair, bit 0 picks RX over TX
    typedef enum logic [SRC_W-1:0] {
        SRC_TX1 = 2'd0,
        SRC_RX1 = 2'd1,
        SRC_TX2 = 2'd2,
        SRC_RX2 = 2'd3
    } src_e;

    typedef struct packed {
        logic vld;
        src_e src;
    } lane_sel_t;

    typedef struct packed {
        lane_sel_t [DP_LANES-1:0] dp;
        logic                     ss_vld;
        logic                     ss_pair;
        logic                     pwr_dn;
    } route_t;

    function automatic mode_e decode_mode(input logic m1, input logic m0);
        case ({m1, m0})
            2'b00:   return MODE_OFF;
            2'b01:   return MODE_USB;
            2'b10:   return MODE_DP4;
            default: return MODE_USB_DP2;
        endcase
    endfunction

    // unflipped lane order for the DisplayPort lanes
    function automatic src_e dp_base_src(input int lane);
        case (lane)
            0:       return SRC_TX2;
            1:       return SRC_RX2;
            2:       return SRC_RX1;
            default: return SRC_TX1;
        endcase
    endfunction

    // orientation swaps connector pair 1 and pair 2
    function automatic src_e flip_src(input src_e s, input logic flip);
        return src_e'({s[1] ^ flip, s[0]});
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/release_gate.sv
module release_gate (
    input  logic clk,
    input  logic rst,
    input  logic m0_sync_i,
    output logic held_o
);
    logic held_q;
    logic seen_high_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q      <= 1'b1;
            seen_high_q <= 1'b0;
        end else if (held_q) begin
            if (m0_sync_i)        seen_high_q <= 1'b1;
            else if (seen_high_q) held_q      <= 1'b0;
        end
    end

    assign held_o = held_q;
endmodule

// File: rtl/sbu_timer.sv
module sbu_timer #(
    parameter int TIMEOUT_CYC = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic dp_en_i,
    output logic conn_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    logic [CNT_W-1:0] low_cnt_q;
    logic             conn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            conn_q    <= 1'b0;
            low_cnt_q <= '0;
        end else if (dp_en_i) begin
            conn_q    <= 1'b1;
            low_cnt_q <= '0;
        end else if (conn_q) begin
            if (low_cnt_q == LIMIT) begin
                conn_q    <= 1'b0;
                low_cnt_q <= '0;
            end else begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    assign conn_o = conn_q;
endmodule

// File: rtl/lane_router.sv
module lane_router
    import typec_mux_pkg::*;
(
    input  mode_e  mode_i,
    input  logic   flip_i,
    output route_t route_o
);
    always_comb begin
        route_o = '0;
        case (mode_i)
            MODE_OFF: begin
                route_o.pwr_dn = 1'b1;
            end
            MODE_USB: begin
                route_o.ss_vld  = 1'b1;
                route_o.ss_pair = flip_i;
            end
            MODE_DP4: begin
                for (int i = 0; i < DP_LANES; i++) begin
                    route_o.dp[i].vld = 1'b1;
                    route_o.dp[i].src = flip_src(dp_base_src(i), flip_i);
                end
            end
            default: begin
                route_o.ss_vld  = 1'b1;
                route_o.ss_pair = flip_i;
                for (int i = 0; i < DP2_LANES; i++) begin
                    route_o.dp[i].vld = 1'b1;
                    route_o.dp[i].src = flip_src(dp_base_src(i), flip_i);
                end
            end
        endcase
    end
endmodule

// File: rtl/typec_altmode_ctrl.sv
module typec_altmode_ctrl
    import typec_mux_pkg::*;
#(
    parameter int CLK_KHZ    = 250000,
    parameter int TIMEOUT_US = 2000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode1_i,
    input  logic                      mode0_i,
    input  logic                      orient_i,
    output logic [DP_LANES*SRC_W-1:0] dp_src_o,
    output logic [DP_LANES-1:0]       dp_vld_o,
    output logic                      ss_vld_o,
    output logic                      ss_pair_o,
    output logic                      sbu_conn_o,
    output logic                      sbu_swap_o,
    output logic                      pwr_dn_o
);
    localparam int TIMEOUT_CYC = CLK_KHZ * TIMEOUT_US / 1000;

    logic [2:0] pins_s;
    logic       s_m1, s_m0, s_orient;
    logic       held;
    logic       m1_eff;
    mode_e      eff_mode;
    route_t     route;

    pin_sync #(.WIDTH(3), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({mode1_i, mode0_i, orient_i}),
        .q_o (pins_s)
    );

    assign {s_m1, s_m0, s_orient} = pins_s;

    release_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .m0_sync_i (s_m0),
        .held_o    (held)
    );

    assign m1_eff   = s_m1 & ~held;
    assign eff_mode = held ? MODE_USB : decode_mode(s_m1, s_m0);

    lane_router u_router (
        .mode_i  (eff_mode),
        .flip_i  (s_orient),
        .route_o (route)
    );

    sbu_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .dp_en_i (m1_eff),
        .conn_o  (sbu_conn_o)
    );

    for (genvar g = 0; g < DP_LANES; g++) begin : g_lane
        assign dp_src_o[g*SRC_W +: SRC_W] = route.dp[g].src;
        assign dp_vld_o[g]                = route.dp[g].vld;
    end

    assign ss_vld_o   = route.ss_vld;
    assign ss_pair_o  = route.ss_pair;
    assign pwr_dn_o   = route.pwr_dn;
    assign sbu_swap_o = s_orient;
endmodule

// File: rtl/typec_altmode_chk.sv
module typec_altmode_chk (
    input logic       clk,
    input logic       rst,
    input logic       held,
    input logic       m1_eff,
    input logic       s_orient,
    input logic [7:0] dp_src_o,
    input logic [3:0] dp_vld_o,
    input logic       ss_vld_o,
    input logic       ss_pair_o,
    input logic       sbu_conn_o,
    input logic       pwr_dn_o
);
    // R2
    forced_usb_chk: assert property (@(posedge clk) disable iff (rst)
        held |-> (ss_vld_o && !pwr_dn_o && dp_vld_o == 4'd0));

    // R3
    release_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !held |=> !held);

    // R4
    pwr_dn_idle_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_dn_o |-> (dp_vld_o == 4'd0 && !ss_vld_o));

    // R5
    ss_pair_orient_chk: assert property (@(posedge clk) disable iff (rst)
        ss_vld_o |-> (ss_pair_o == s_orient));

    // R6
    dp4_lane0_chk: assert property (@(posedge clk) disable iff (rst)
        (dp_vld_o == 4'hF) |-> (dp_src_o[1:0] == (s_orient ? 2'd0 : 2'd2) && !ss_vld_o));

    // R8
    sbu_connect_chk: assert property (@(posedge clk) disable iff (rst)
        m1_eff |=> sbu_conn_o);

    // R9
    sbu_open_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sbu_conn_o) |-> !$past(m1_eff));
endmodule

bind typec_altmode_ctrl typec_altmode_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .held       (held),
    .m1_eff     (m1_eff),
    .s_orient   (s_orient),
    .dp_src_o   (dp_src_o),
    .dp_vld_o   (dp_vld_o),
    .ss_vld_o   (ss_vld_o),
    .ss_pair_o  (ss_pair_o),
    .sbu_conn_o (sbu_conn_o),
    .pwr_dn_o   (pwr_dn_o)
);

// File: tb/test_typec_altmode_ctrl.sv
module test_typec_altmode_ctrl;
    localparam int CLK_KHZ    = 10;
    localparam int TIMEOUT_US = 2000;
    localparam int T          = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode1 = 1'b0, mode0 = 1'b0, orient = 1'b0;
    logic [7:0] dp_src;
    logic [3:0] dp_vld;
    logic       ss_vld, ss_pair, sbu_conn, sbu_swap, pwr_dn;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    typec_altmode_ctrl #(.CLK_KHZ(CLK_KHZ), .TIMEOUT_US(TIMEOUT_US)) i_typec_altmode_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode1_i    (mode1),
        .mode0_i    (mode0),
        .orient_i   (orient),
        .dp_src_o   (dp_src),
        .dp_vld_o   (dp_vld),
        .ss_vld_o   (ss_vld),
        .ss_pair_o  (ss_pair),
        .sbu_conn_o (sbu_conn),
        .sbu_swap_o (sbu_swap),
        .pwr_dn_o   (pwr_dn)
    );

    function automatic logic [14:0] route_vec();
        return {pwr_dn, ss_vld, ss_pair, dp_vld, dp_src};
    endfunction

    // {pwr_dn, ss_vld, ss_pair, dp_vld[3:0], dp_src[7:0]}
    function automatic logic [14:0] exp_route(input logic m1, input logic m0, input logic f);
        case ({m1, m0})
            2'b00: return {1'b1, 1'b0, 1'b0, 4'h0, 8'h00};
            2'b01: return {1'b0, 1'b1, f,    4'h0, 8'h00};
            2'b10: return {1'b0, 1'b0, 1'b0, 4'hF, (f ? 8'hB4 : 8'h1E)};
            default: return {1'b0, 1'b1, f, 4'h3, (f ? 8'h04 : 8'h0E)};
        endcase
    endfunction

    task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic m1, input logic m0, input logic f);
        @(negedge clk);
        mode1 = m1; mode0 = m0; orient = f;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 route in reset", route_vec(), {1'b0, 1'b1, 1'b0, 4'h0, 8'h00});
        check("R1 sbu open in reset", {14'd0, sbu_conn}, 15'd0);
        rst = 1'b0;
        settle();
        check("R1 route after reset", route_vec(), {1'b0, 1'b1, 1'b0, 4'h0, 8'h00});
    endtask

    task automatic t_hold();
        drive(1'b1, 1'b0, 1'b1);
        settle();
        check("R2 held with dp pins", route_vec(), {1'b0, 1'b1, 1'b1, 4'h0, 8'h00});
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R2 sbu open while held", {14'd0, sbu_conn}, 15'd0);
        drive(1'b0, 1'b0, 1'b0);
        settle();
        check("R2 held with off pins", route_vec(), {1'b0, 1'b1, 1'b0, 4'h0, 8'h00});
    endtask

    task automatic t_release();
        drive(1'b0, 1'b1, 1'b0);
        settle();
        check("R3 still held while pin high", route_vec(), {1'b0, 1'b1, 1'b0, 4'h0, 8'h00});
        drive(1'b0, 1'b0, 1'b0);
        settle();
        check("R3 R4 released to power down", route_vec(), exp_route(1'b0, 1'b0, 1'b0));
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 8; k++) begin
            logic m1, m0, f;
            string tag;
            {m1, m0, f} = 3'(k);
            tag = (k < 2) ? "R4" : (k < 4) ? "R5" : (k < 6) ? "R6" : "R7";
            drive(m1, m0, f);
            settle();
            check($sformatf("%s R3 sweep m1=%0b m0=%0b f=%0b", tag, m1, m0, f),
                  route_vec(), exp_route(m1, m0, f));
        end
    endtask

    task automatic t_latency();
        drive(1'b1, 1'b0, 1'b0);
        settle();
        @(negedge clk);
        mode1 = 1'b0; mode0 = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R8 unchanged after one edge", route_vec(), exp_route(1'b1, 1'b0, 1'b0));
        @(posedge clk); @(negedge clk);
        check("R8 changed after two edges", route_vec(), exp_route(1'b0, 1'b1, 1'b0));
    endtask

    task automatic t_sbu();
        drive(1'b1, 1'b0, 1'b0);
        settle();
        check("R8 sbu connected unflipped", {13'd0, sbu_conn, sbu_swap}, 15'b10);
        drive(1'b1, 1'b0, 1'b1);
        settle();
        check("R8 sbu connected flipped", {13'd0, sbu_conn, sbu_swap}, 15'b11);
        @(negedge clk);
        mode1 = 1'b0;
        repeat (T + 2) @(posedge clk);
        @(negedge clk);
        check("R9 still connected at limit", {14'd0, sbu_conn}, 15'd1);
        @(posedge clk); @(negedge clk);
        check("R9 open after limit", {14'd0, sbu_conn}, 15'd0);
    endtask

    task automatic t_restart();
        drive(1'b1, 1'b1, 1'b0);
        settle();
        check("R10 reconnect after open", {14'd0, sbu_conn}, 15'd1);
        @(negedge clk);
        mode1 = 1'b0;
        repeat (T) @(posedge clk);
        @(negedge clk);
        mode1 = 1'b1;
        @(negedge clk);
        mode1 = 1'b0;
        repeat (T + 2) @(posedge clk);
        @(negedge clk);
        check("R10 low periods not summed", {14'd0, sbu_conn}, 15'd1);
        @(posedge clk); @(negedge clk);
        check("R10 open after fresh timeout", {14'd0, sbu_conn}, 15'd0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1-bench actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        t_hold();
        t_release();
        t_sweep();
        t_latency();
        t_sbu();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule